// File: doc/BRIEF.md
# RoCEv2 Invariant CRC Generator

This block produces the 32-bit invariant CRC that closes a RoCEv2 frame. The frame arrives one byte per clock cycle, starting with the first Ethernet header byte. A byte-valid qualifier and start and end markers travel with the bytes. The trailing four CRC bytes are not part of the input; the block computes them and then emits them itself.

Fields that routers may rewrite in transit are not covered by the checksum. The block drops the Ethernet header completely. It replaces the rewritable IP, UDP and transport-header bytes with all-ones before they reach the CRC. A run of eight all-ones bytes stands in for the absent link-level route header in front of the IP header. The block folds that run into the CRC seed, so it costs no clock cycles.

The CRC uses the common reflected CRC-32. When the frame ends, the block pulses a done strobe and presents the 32-bit result. It then streams the result as four bytes, most-significant byte first, ready to append after the payload.

Top module: `roce_icrc_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `app_valid` are 0 and `icrc` is 0.
- R2: Packet bytes at positions 0 to 13 (the Ethernet header, position 0 being the byte marked by `in_sop`) have no effect on `icrc`.
- R3: Before packet byte 14, the CRC absorbs eight bytes of value 0xFF.
- R4: Packet bytes at positions 15, 22, 24, 25, 40, 41 and 46 enter the CRC as 0xFF whatever their value.
- R5: Every other packet byte from position 14 up to and including the `in_eop` byte enters the CRC unchanged. The CRC is the reflected CRC-32: polynomial 0x04C11DB7, processed LSB first, initial value 0xFFFFFFFF, and the result inverted.
- R6: `done` is high for exactly the one cycle after the accepted `in_eop` byte, and `icrc` carries the result in that cycle. `icrc` then holds its value until the next `done`.
- R7: In the four cycles right after `done`, `app_valid` is high and `app_byte` carries `icrc[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`, in that order. `app_valid` is low in the cycle after those four.
- R8: Cycles with `in_valid` low inside a packet do not advance the byte position and do not change the result.
- R9: Valid bytes that arrive after an `in_eop` and before the next `in_sop` are ignored: they produce no `done` and do not affect the next packet.
- R10: An `in_sop` in the middle of a packet abandons that packet and restarts position counting at 0.
- R11: A packet that ends before position 15 yields the inverted CRC of the eight 0xFF bytes alone, when it ends before position 14, or of those bytes plus byte 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_byte | input | 8 | Packet byte |
| in_valid | input | 1 | `in_byte` carries a packet byte this cycle |
| in_sop | input | 1 | This byte is packet position 0 |
| in_eop | input | 1 | This byte is the last payload byte |
| icrc | output | 32 | Invariant CRC of the latest finished packet |
| done | output | 1 | One-cycle strobe: `icrc` was just updated |
| app_byte | output | 8 | Byte of the append stream |
| app_valid | output | 1 | `app_byte` is valid |

## Verification
Two situations are hard to reach from the ports. The first is a packet that is abandoned halfway by a new start marker. The second is stray valid bytes that arrive between packets. In both, a fault leaves no visible trace until a later packet's CRC comes out wrong. The stimulus therefore sends a partial packet straight into a full one, and sends a burst of unframed valid bytes before a normal packet. Each result is compared with a CRC of the clean packet, computed independently in the bench. The insensitivity rules are exercised by sending one frame, then corrupting only its header bytes or only its rewritable bytes, and requiring the same result again.

// File: rtl/icrc_pkg.sv
package icrc_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned CRC_W       = 32;
    localparam int unsigned APPEND_N    = CRC_W / BYTE_W;
    localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT  = '1;

    // header geometry
    localparam int unsigned ETH_HDR_LEN  = 14;
    localparam int unsigned ROUTE_FILL_N = 8;

    // positions whose contents may be rewritten in transit
    localparam int unsigned POS_TOS      = 15;
    localparam int unsigned POS_TTL      = 22;
    localparam int unsigned POS_IPSUM_H  = 24;
    localparam int unsigned POS_IPSUM_L  = 25;
    localparam int unsigned POS_UDPSUM_H = 40;
    localparam int unsigned POS_UDPSUM_L = 41;
    localparam int unsigned POS_BTH_FLAG = 46;

    // one byte through the reflected CRC, LSB first
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  state,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        c = state ^ {{(CRC_W-BYTE_W){1'b0}}, data};
        for (int b = 0; b < BYTE_W; b++) begin
            c = c[0] ? ((c >> 1) ^ POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

    // CRC state after n all-ones bytes from the initial value
    function automatic logic [CRC_W-1:0] crc_after_fill(input int unsigned n);
        logic [CRC_W-1:0] c;
        c = CRC_INIT;
        for (int unsigned k = 0; k < n; k++) begin
            c = crc_step_byte(c, '1);
        end
        return c;
    endfunction

    function automatic logic is_variant_pos(input int unsigned pos);
        return (pos == POS_TOS)      || (pos == POS_TTL)      ||
               (pos == POS_IPSUM_H)  || (pos == POS_IPSUM_L)  ||
               (pos == POS_UDPSUM_H) || (pos == POS_UDPSUM_L) ||
               (pos == POS_BTH_FLAG);
    endfunction

endpackage

// File: rtl/icrc_pos_track.sv
module icrc_pos_track
    import icrc_pkg::*;
#(
    parameter int unsigned POS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              acc_first,
    output logic              acc_last,
    output logic              feed,
    output logic [BYTE_W-1:0] feed_byte
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic             in_pkt;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [POS_W-1:0] cur_pos;
    logic             acc;

    always_comb begin
        trk_d     = trk_q;
        cur_pos   = in_sop ? '0 : trk_q.pos;
        acc       = in_valid && (in_sop || trk_q.in_pkt);
        acc_first = acc && in_sop;
        acc_last  = acc && in_eop;
        feed      = acc && (int'(cur_pos) >= ETH_HDR_LEN);
        feed_byte = is_variant_pos(int'(cur_pos)) ? '1 : in_byte;
        if (acc) begin
            trk_d.in_pkt = !in_eop;
            trk_d.pos    = (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_SOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !in_eop) |=> (trk_q.pos == 1 && trk_q.in_pkt)); // R10

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_q.in_pkt && !in_sop) |=> $stable(trk_q.pos)); // R9

endmodule

// File: rtl/icrc_crc_core.sv
module icrc_crc_core
    import icrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_first,
    input  logic              acc_last,
    input  logic              feed,
    input  logic [BYTE_W-1:0] feed_byte,
    output logic [CRC_W-1:0]  icrc,
    output logic              done
);

    localparam logic [CRC_W-1:0] SEED = crc_after_fill(ROUTE_FILL_N);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] res;
        logic             done;
    } core_t;

    core_t core_d, core_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] nxt;

    always_comb begin
        core_d      = core_q;
        base        = acc_first ? SEED : core_q.crc;
        nxt         = feed ? crc_step_byte(base, feed_byte) : base;
        core_d.crc  = nxt;
        core_d.done = acc_last;
        if (acc_last) begin
            core_d.res = ~nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '{crc: SEED, res: '0, done: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign icrc = core_q.res;
    assign done = core_q.done;

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!feed && !acc_first) |=> $stable(core_q.crc)); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.done) |-> $past(acc_last)); // R6

endmodule

// File: rtl/icrc_append.sv
module icrc_append
    import icrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CRC_W-1:0]  word,
    output logic [BYTE_W-1:0] app_byte,
    output logic              app_valid
);

    localparam int unsigned CNT_W = $clog2(APPEND_N + 1);

    typedef struct packed {
        logic [CRC_W-1:0] sh;
        logic [CNT_W-1:0] left;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.sh   = word;
            ser_d.left = CNT_W'(APPEND_N);
        end else if (ser_q.left != '0) begin
            ser_d.sh   = ser_q.sh << BYTE_W;
            ser_d.left = ser_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign app_valid = (ser_q.left != '0);
    assign app_byte  = ser_q.sh[CRC_W-1 -: BYTE_W];

    AST_APP_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_valid) |-> $past(load)); // R7

endmodule

// File: rtl/roce_icrc_gen.sv
module roce_icrc_gen #(
    parameter int unsigned POS_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_byte,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic [31:0] icrc,
    output logic        done,
    output logic [7:0]  app_byte,
    output logic        app_valid
);

    logic       acc_first;
    logic       acc_last;
    logic       feed;
    logic [7:0] feed_byte;

    icrc_pos_track #(.POS_W(POS_W)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_byte   (in_byte),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .acc_first (acc_first),
        .acc_last  (acc_last),
        .feed      (feed),
        .feed_byte (feed_byte)
    );

    icrc_crc_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_first (acc_first),
        .acc_last  (acc_last),
        .feed      (feed),
        .feed_byte (feed_byte),
        .icrc      (icrc),
        .done      (done)
    );

    icrc_append i_append (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .word      (icrc),
        .app_byte  (app_byte),
        .app_valid (app_valid)
    );

    AST_ICRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(icrc)); // R6

    AST_DONE_SINGLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !app_valid || $past(done)); // R7

endmodule

// File: tb/test_roce_icrc_gen.sv
`timescale 1ns/1ps
module test_roce_icrc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [31:0] icrc;
    logic        done;
    logic [7:0]  app_byte;
    logic        app_valid;

    int total = 0;
    int bad = 0;
    logic [7:0] pkt [0:255];

    always #2 clk = ~clk;

    roce_icrc_gen i_roce_icrc_gen (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .icrc(icrc), .done(done),
        .app_byte(app_byte), .app_valid(app_valid)
    );

    // stimulus table: length, first byte, increment, gaps
    localparam int NVEC = 5;
    localparam int          VEC_LEN  [NVEC] = '{60, 80, 48, 100, 64};
    localparam logic [7:0]  VEC_SEED [NVEC] = '{8'h00, 8'h5A, 8'hC3, 8'h01, 8'hFF};
    localparam logic [7:0]  VEC_STEP [NVEC] = '{8'h01, 8'h03, 8'h07, 8'h0D, 8'h00};
    localparam bit          VEC_GAP  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_step(input logic [31:0] c0, input logic [7:0] b);
        logic [31:0] c;
        c = c0 ^ {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic logic [31:0] ref_icrc(input int len);
        logic [31:0] c;
        logic [7:0]  b;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 8; k++) c = ref_step(c, 8'hFF);
        for (int i = 14; i < len; i++) begin
            b = pkt[i];
            if (i == 15 || i == 22 || i == 24 || i == 25 || i == 40 || i == 41 || i == 46) b = 8'hFF;
            c = ref_step(c, b);
        end
        return ~c;
    endfunction

    task automatic fill(input int len, input logic [7:0] seed, input logic [7:0] step);
        for (int i = 0; i < len; i++) pkt[i] = seed + 8'(i) * step;
    endtask

    // drives bytes 0..len-1; returns at the negedge after the last byte's clock edge
    task automatic send_pkt(input int len, input bit gaps, input bit with_eop);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 2)) begin
                in_valid = 1'b0; in_byte = 8'hA5; in_sop = 1'b1; in_eop = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = pkt[i];
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = 8'h00;
    endtask

    task automatic check_out(input logic [31:0] exp, input string tag);
        chk(done === 1'b1, {"R6 done ", tag}, {31'h0, done}, 32'h1);
        chk(icrc === exp, {"R5 icrc ", tag}, icrc, exp);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) chk(done === 1'b0, {"R6 done width ", tag}, {31'h0, done}, 32'h0);
            chk(app_valid === 1'b1, {"R7 app_valid ", tag}, {31'h0, app_valid}, 32'h1);
            chk(app_byte === exp[31-8*k -: 8], {"R7 app_byte ", tag}, {24'h0, app_byte}, {24'h0, exp[31-8*k -: 8]});
        end
        @(negedge clk);
        chk(app_valid === 1'b0, {"R7 app end ", tag}, {31'h0, app_valid}, 32'h0);
        chk(icrc === exp, {"R6 hold ", tag}, icrc, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] exp;
        logic [31:0] first;
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && app_valid === 1'b0, "R1 outputs in reset", {30'h0, done, app_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R1 done after reset", {31'h0, done}, 32'h0);
        chk(app_valid === 1'b0, "R1 app_valid after reset", {31'h0, app_valid}, 32'h0);
        chk(icrc === 32'h0, "R1 icrc after reset", icrc, 32'h0);

        // table walk; gap rows exercise R8
        for (int v = 0; v < NVEC; v++) begin
            fill(VEC_LEN[v], VEC_SEED[v], VEC_STEP[v]);
            exp = ref_icrc(VEC_LEN[v]);
            send_pkt(VEC_LEN[v], VEC_GAP[v], 1'b1);
            check_out(exp, VEC_GAP[v] ? "R8 table gaps" : "table");
        end

        // R2: Ethernet header bytes do not matter
        fill(70, 8'h11, 8'h05);
        first = ref_icrc(70);
        send_pkt(70, 1'b0, 1'b1);
        check_out(first, "R2 base");
        for (int i = 0; i < 14; i++) pkt[i] = ~pkt[i] + 8'(i);
        send_pkt(70, 1'b0, 1'b1);
        check_out(first, "R2 header changed");

        // R4: rewritable bytes do not matter
        pkt[15] = 8'h00; pkt[22] = 8'h01; pkt[24] = 8'h7E; pkt[25] = 8'h3C;
        pkt[40] = 8'h99; pkt[41] = 8'h42; pkt[46] = 8'h00;
        send_pkt(70, 1'b1, 1'b1);
        check_out(first, "R4 variant bytes changed");

        // R3 / R11: short packets
        fill(14, 8'h20, 8'h01);
        exp = ref_icrc(14);
        send_pkt(14, 1'b0, 1'b1);
        check_out(exp, "R3 fill only len14");
        fill(5, 8'h80, 8'h02);
        send_pkt(5, 1'b0, 1'b1);
        check_out(exp, "R11 len5");
        fill(15, 8'h33, 8'h01);
        exp = ref_icrc(15);
        send_pkt(15, 1'b0, 1'b1);
        check_out(exp, "R11 len15");

        // R9: stray bytes between packets
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = 8'hC0 + 8'(i); in_sop = 1'b0; in_eop = (i == 3);
            @(negedge clk);
            in_valid = 1'b0; in_eop = 1'b0;
            chk(done === 1'b0, "R9 no done on stray", {31'h0, done}, 32'h0);
        end
        fill(52, 8'h44, 8'h09);
        exp = ref_icrc(52);
        send_pkt(52, 1'b0, 1'b1);
        check_out(exp, "R9 after stray");

        // R10: restart mid-packet
        fill(30, 8'hE1, 8'h0B);
        send_pkt(30, 1'b0, 1'b0);
        @(negedge clk);
        chk(done === 1'b0, "R10 no done on abandoned", {31'h0, done}, 32'h0);
        fill(58, 8'h07, 8'h11);
        exp = ref_icrc(58);
        send_pkt(58, 1'b0, 1'b1);
        check_out(exp, "R10 restart");

        repeat (3) @(negedge clk);
        chk(icrc === exp, "R6 idle hold", icrc, exp);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule